// File: doc/BRIEF.md
# Three-wire serial EEPROM controller

This block is the master side of a three-wire serial EEPROM. The memory holds 16-bit words and has either 64 or 128 of them. A host issues one request at a time: a word address, a read-or-write flag and, for writes, a 16-bit word. The controller then builds the whole serial instruction: chip select, a divided serial clock, a start bit, a two-bit opcode, the address and, for writes, the data word.

On a read, the EEPROM first presents a leading zero. The controller checks that bit, drops it, and assembles the 16 data bits that follow. On a write, the controller closes the instruction and waits out a chip-select gap. It then raises chip select again with the serial clock parked low and watches the device's data line until the device reports ready, or until a poll timeout expires. Either outcome ends with a one-cycle done pulse. The address width parameter (6 or 8) selects the array size.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, chip select, serial clock, serial data out, busy, done and err are all 0.
- R2: Each instruction begins when chip select rises. The controller then sends a start bit of 1, an opcode (10 for read, 01 for write), the ADDR_W address bits MSB first and, for a write only, the 16 data bits MSB first. Each bit changes only after a serial-clock falling edge and is held stable across the rising edge.
- R3: On a read, the first bit sampled on the rising edge after the last address bit is the device's leading zero, and it is discarded. The next 16 sampled bits, MSB first, appear on rd_data in the cycle where done pulses, with err low.
- R4: If the leading bit of a read is 1, done pulses with err high.
- R5: After a write instruction, chip select goes low and then high again, with the serial clock held low throughout. Done is not reported until the data-in line reads 1. Err stays low on this path.
- R6: If data-in stays 0 for POLL_LIMIT cycles of polling, chip select drops and done pulses with err high. Err is never high outside a done cycle.
- R7: A request presented while busy is high is ignored: it starts no instruction and changes neither the address nor the data sent.
- R8: Busy rises in the cycle after a request is accepted. It falls in the same cycle as a one-cycle done pulse.
- R9: While the serial clock runs, each high phase and each low phase lasts HALF_DIV system cycles. The serial clock is low whenever chip select is low.
- R10: Chip select stays low for at least 2*HALF_DIV system cycles before every rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| rd_data | output | 16 | Word returned by the last read |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_do | output | 1 | Serial data to the EEPROM input |
| ee_di | input | 1 | Serial data from the EEPROM output |

## Verification
The bench writes a distinct arithmetic pattern to every address of the small array and reads every address back. A wrong bit order, an off-by-one at the leading zero, or a mixed-up address shows up as a mismatch in one of these transfers. All-ones and all-zeros words at the lowest and highest addresses separate stuck data bits from address errors. Three other patterns each isolate one path: a device that never releases busy, a device that is absent (leading bit 1), and a second request sent mid-transaction. These tell the timeout, the leading-bit check and the idle-only acceptance apart from the normal write-poll path, whose ready delay the bench model also checks.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_POLL  = 2'd3
  } uw_state_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/uwire_sk_gen.sv
module uwire_sk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sk,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          phase_end;

  assign phase_end = (cnt == CW'(HALF_DIV - 1));
  assign rise_now  = run && !sk && phase_end;
  assign fall_now  = run &&  sk && phase_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (phase_end) begin
      cnt <= '0;
      sk  <= ~sk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uwire_wait_cnt.sv
module uwire_wait_cnt #(
  parameter int LIMIT = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  output logic [$clog2(LIMIT+1)-1:0]   count,
  output logic                         expired
);
  localparam int CW = $clog2(LIMIT + 1);

  assign expired = run && (count == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)
      count <= '0;
    else if (!expired)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/uwire_di_sync.sv
module uwire_di_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst)
      pipe <= '0;
    else
      pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl #(
  parameter int ADDR_W     = 6,
  parameter int WORD_W     = 16,
  parameter int HALF_DIV   = 50,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_do,
  input  logic              ee_di
);
  import uwire_pkg::*;

  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int FRAME_W  = CMD_BITS + WORD_W;
  localparam int RD_RISES = CMD_BITS + 1 + WORD_W;
  localparam int WR_RISES = CMD_BITS + WORD_W;
  localparam int GAP_CYC  = 2 * HALF_DIV;
  localparam int RC_W     = $clog2(RD_RISES + 1);
  localparam int PC_W     = $clog2(POLL_LIMIT + 1);
  localparam int GC_W     = $clog2(GAP_CYC + 1);
  localparam int SYNC_LAT = 3;

  uw_state_t            state;
  logic                 is_wr, final_leg, err_pend, last_rise;
  logic [FRAME_W-1:0]   sreg;
  logic [RC_W-1:0]      rise_cnt;
  logic [WORD_W:0]      rdsr;
  logic                 di_s, rise_now, fall_now;
  logic                 gap_exp, poll_exp;
  logic [GC_W-1:0]      gap_cnt;
  logic [PC_W-1:0]      poll_cnt;
  logic [RC_W-1:0]      last_idx;

  assign last_idx = is_wr ? RC_W'(WR_RISES - 1) : RC_W'(RD_RISES - 1);

  uwire_di_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(ee_di), .dout(di_s)
  );

  uwire_sk_gen #(.HALF_DIV(HALF_DIV)) u_skgen (
    .clk(clk), .rst(rst), .run(state == ST_SHIFT),
    .sk(ee_sk), .rise_now(rise_now), .fall_now(fall_now)
  );

  uwire_wait_cnt #(.LIMIT(GAP_CYC)) u_gap (
    .clk(clk), .rst(rst), .run(state == ST_GAP),
    .count(gap_cnt), .expired(gap_exp)
  );

  uwire_wait_cnt #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .run(state == ST_POLL),
    .count(poll_cnt), .expired(poll_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      is_wr     <= 1'b0;
      final_leg <= 1'b0;
      err_pend  <= 1'b0;
      last_rise <= 1'b0;
      sreg      <= '0;
      rise_cnt  <= '0;
      rdsr      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rd_data   <= '0;
      ee_cs     <= 1'b0;
      ee_do     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            sreg      <= {1'b1, (req_write ? OP_WRITE : OP_READ), req_addr,
                          (req_write ? req_wdata : WORD_W'(0))};
            ee_do     <= 1'b1;
            ee_cs     <= 1'b1;
            is_wr     <= req_write;
            busy      <= 1'b1;
            rise_cnt  <= '0;
            last_rise <= 1'b0;
            final_leg <= 1'b0;
            err_pend  <= 1'b0;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise_now) begin
            rise_cnt <= rise_cnt + 1'b1;
            if (rise_cnt >= RC_W'(CMD_BITS))
              rdsr <= {rdsr[WORD_W-1:0], di_s};
            if (rise_cnt == last_idx)
              last_rise <= 1'b1;
          end
          if (fall_now) begin
            if (last_rise) begin
              ee_cs <= 1'b0;
              ee_do <= 1'b0;
              state <= ST_GAP;
              if (!is_wr) begin
                final_leg <= 1'b1;
                err_pend  <= rdsr[WORD_W];
              end
            end else begin
              sreg  <= sreg << 1;
              ee_do <= sreg[FRAME_W-2];
            end
          end
        end
        ST_GAP: begin
          if (gap_exp) begin
            if (final_leg) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              err   <= err_pend;
              state <= ST_IDLE;
              if (!is_wr)
                rd_data <= rdsr[WORD_W-1:0];
            end else begin
              ee_cs <= 1'b1;
              state <= ST_POLL;
            end
          end
        end
        ST_POLL: begin
          if ((poll_cnt >= PC_W'(SYNC_LAT)) && di_s) begin
            ee_cs     <= 1'b0;
            final_leg <= 1'b1;
            state     <= ST_GAP;
          end else if (poll_exp) begin
            ee_cs     <= 1'b0;
            final_leg <= 1'b1;
            err_pend  <= 1'b1;
            state     <= ST_GAP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_ctrl_chk.sv
module uwire_eeprom_ctrl_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do,
  input logic busy,
  input logic done,
  input logic err
);
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int LW = $clog2(GAP_CYC + 2);
  localparam int PW = $clog2(HALF_DIV + 2);

  logic [LW-1:0] low_cnt;
  logic [PW-1:0] ph_cnt;
  logic          sk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= LW'(GAP_CYC);
      ph_cnt  <= '0;
      sk_q    <= 1'b0;
    end else begin
      sk_q <= ee_sk;
      if (ee_cs)
        low_cnt <= '0;
      else if (low_cnt < LW'(GAP_CYC))
        low_cnt <= low_cnt + 1'b1;
      if (ee_sk != sk_q)
        ph_cnt <= PW'(1);
      else if (ph_cnt <= PW'(HALF_DIV))
        ph_cnt <= ph_cnt + 1'b1;
    end
  end

  a_r9_sk_low_without_cs: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);

  a_r9_high_phase_len: assert property (@(posedge clk) disable iff (rst)
    (sk_q && !ee_sk) |-> (ph_cnt == PW'(HALF_DIV)));

  a_r2_do_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sk) |-> $stable(ee_do));

  a_r6_err_only_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  a_r8_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_busy_falls_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r10_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> (low_cnt >= LW'(GAP_CYC)));
endmodule

bind uwire_eeprom_ctrl uwire_eeprom_ctrl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
  .busy(busy), .done(done), .err(err)
);

// File: tb/sim_uwire_eeprom_ctrl.sv
module sim_uwire_eeprom_ctrl;
  localparam int AW    = 6;
  localparam int H     = 4;
  localparam int PLIM  = 300;
  localparam int BUSY  = 60;
  localparam int CMD   = 3 + AW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, err, ee_cs, ee_sk, ee_do, ee_di;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  uwire_eeprom_ctrl #(.ADDR_W(AW), .WORD_W(16), .HALF_DIV(H), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_do(ee_do), .ee_di(ee_di)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- EEPROM device model ----------------
  logic [15:0] mem [0:WORDS-1];
  logic sk_q = 1'b0, cs_q = 1'b0, reading = 1'b0, wr_pend = 1'b0;
  logic absent = 1'b0, stuck = 1'b0, last_start = 1'b0;
  logic [31:0] rx_sr = '0, nsr;
  logic [16:0] out_sr = '0;
  logic [1:0] last_op = '0, op_now;
  logic [AW-1:0] last_addr = '0, wr_addr = '0;
  logic [15:0] last_data = '0, wr_data = '0;
  int rx_cnt = 0, busy_cnt = 0, frames = 0, sess_rises = 0, last_sess_rises = 0;
  int plen = 0, bad_phase = 0, phases = 0, low_len = 1000, min_gap = 1000;

  assign ee_di = absent ? 1'b1 :
                 (ee_cs ? (reading ? out_sr[16] : (busy_cnt == 0)) : 1'b0);

  always @(posedge clk) begin
    sk_q <= ee_sk;
    cs_q <= ee_cs;
    if (busy_cnt > 0 && !stuck) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) mem[wr_addr] <= wr_data;
    end
    if (ee_cs && !cs_q) begin
      rx_cnt <= 0;
      sess_rises <= 0;
      plen <= 1;
      if (low_len < min_gap) min_gap <= low_len;
    end else if (ee_cs) begin
      if (ee_sk != sk_q) begin
        phases <= phases + 1;
        if (plen != H) bad_phase <= bad_phase + 1;
        plen <= 1;
      end else plen <= plen + 1;
      if (ee_sk && !sk_q) begin
        sess_rises <= sess_rises + 1;
        nsr = {rx_sr[30:0], ee_do};
        rx_sr <= nsr;
        rx_cnt <= rx_cnt + 1;
        if (reading) out_sr <= {out_sr[15:0], 1'b0};
        if (rx_cnt + 1 == CMD) begin
          op_now = nsr[CMD-2 -: 2];
          last_start <= nsr[CMD-1];
          last_op <= op_now;
          last_addr <= nsr[AW-1:0];
          frames <= frames + 1;
          if (op_now == 2'b10) begin
            reading <= 1'b1;
            out_sr <= {1'b0, mem[nsr[AW-1:0]]};
          end
        end
        if (rx_cnt + 1 == CMD + 16 && last_op == 2'b01) begin
          last_data <= nsr[15:0];
          wr_pend <= 1'b1;
          wr_addr <= last_addr;
          wr_data <= nsr[15:0];
        end
      end
    end
    if (!ee_cs && cs_q) begin
      reading <= 1'b0;
      last_sess_rises <= sess_rises;
      if (wr_pend) begin
        busy_cnt <= BUSY;
        wr_pend <= 1'b0;
      end
    end
    if (ee_cs) low_len <= 0; else low_len <= low_len + 1;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- request task ----------------
  logic [15:0] got_rd;
  logic got_err;
  int dur;

  task automatic run_req(input logic wr, input logic [AW-1:0] a,
                         input logic [15:0] d, input bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    if (poke) begin
      req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      @(negedge clk);
      req_valid = 1'b0;
    end
    dur = 1;
    while (!done && dur < 60000) begin
      @(negedge clk);
      dur++;
    end
    got_rd = rd_data;
    got_err = err;
    chk(done == 1'b1 && busy == 1'b0, "R8 done with busy low", {busy, done}, 2'b01);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 771) ^ 16'h5A3C;
  endfunction

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk({ee_cs, ee_sk, ee_do, busy, done, err} == 6'b0, "R1 in reset",
        {ee_cs, ee_sk, ee_do, busy, done, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({ee_cs, ee_sk, ee_do, busy, done, err} == 6'b0, "R1 after reset",
        {ee_cs, ee_sk, ee_do, busy, done, err}, 0);

    // write sweep: R2 frame, R5 poll
    for (int a = 0; a < WORDS; a++) begin
      run_req(1'b1, AW'(a), pat(a), 1'b0);
      chk(last_start == 1'b1 && last_op == 2'b01, "R2 write start/opcode",
          {last_start, last_op}, 3'b101);
      chk(last_addr == AW'(a), "R2 write address", last_addr, a);
      chk(last_data == pat(a), "R2 write data", last_data, pat(a));
      chk(got_err == 1'b0 && dur > BUSY, "R5 ready before done", dur, BUSY);
      chk(last_sess_rises == 0, "R5 sk low while polling", last_sess_rises, 0);
    end

    // read sweep: R2 and R3
    for (int a = 0; a < WORDS; a++) begin
      run_req(1'b0, AW'(a), 16'h0, 1'b0);
      chk(last_start == 1'b1 && last_op == 2'b10, "R2 read start/opcode",
          {last_start, last_op}, 3'b110);
      chk(last_addr == AW'(a), "R2 read address", last_addr, a);
      chk(got_rd == pat(a) && got_err == 1'b0, "R3 read data", got_rd, pat(a));
    end

    // corner words at corner addresses
    run_req(1'b1, AW'(0), 16'hFFFF, 1'b0);
    run_req(1'b1, AW'(WORDS - 1), 16'h0000, 1'b0);
    run_req(1'b0, AW'(0), 16'h0, 1'b0);
    chk(got_rd == 16'hFFFF, "R3 all ones at low address", got_rd, 16'hFFFF);
    run_req(1'b0, AW'(WORDS - 1), 16'h0, 1'b0);
    chk(got_rd == 16'h0000, "R3 all zeros at high address", got_rd, 0);

    // R7: second request while busy
    begin
      int f0;
      f0 = frames;
      run_req(1'b1, AW'(5), 16'h1234, 1'b1);
      chk(frames == f0 + 1, "R7 one instruction only", frames, f0 + 1);
      chk(last_addr == AW'(5) && last_data == 16'h1234, "R7 request kept",
          last_data, 16'h1234);
      run_req(1'b0, AW'(5), 16'h0, 1'b1);
      chk(frames == f0 + 2 && got_rd == 16'h1234, "R7 read unaffected",
          got_rd, 16'h1234);
      chk(mem[AW'(~5)] == pat(WORDS - 1 - 5), "R7 no stray write",
          mem[AW'(~5)], pat(WORDS - 1 - 5));
    end

    // R4: absent device, leading bit reads 1
    absent = 1'b1;
    run_req(1'b0, AW'(3), 16'h0, 1'b0);
    chk(got_err == 1'b1, "R4 leading one flags err", got_err, 1);
    absent = 1'b0;
    run_req(1'b0, AW'(3), 16'h0, 1'b0);
    chk(got_err == 1'b0 && got_rd == pat(3), "R4 err clears on good read", got_rd, pat(3));

    // R6: device never ready
    stuck = 1'b1;
    run_req(1'b1, AW'(9), 16'hBEEF, 1'b0);
    chk(got_err == 1'b1, "R6 timeout err", got_err, 1);
    chk(dur >= PLIM, "R6 poll lasted limit", dur, PLIM);
    chk(ee_cs == 1'b0, "R6 cs dropped", ee_cs, 0);
    stuck = 1'b0;

    // R9 / R10 global timing
    chk(bad_phase == 0 && phases > 100, "R9 phase length", bad_phase, 0);
    chk(min_gap >= 2 * H, "R10 cs low gap", min_gap, 2 * H);

    repeat (BUSY + 5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule